// File: doc/BRIEF.md
# Dual-Slope Center-Aligned PWM Timer

The block is a 16-bit counter that climbs from zero to a ceiling value and then falls back to zero, over and over. It drives one waveform pin from a compare unit, so the pulses are centered in each period. The counter steps only on ticks from a clock divider. The divider passes the clock through undivided or divides it by 8, 64, 256 or 1024. The ceiling comes from one of two places: a dedicated ceiling register, or the compare register itself.

Both the ceiling register and the compare register are double buffered. Software writes land in a buffer, and the live copy is refreshed at a turning point of the count. The reload-point select chooses where that refresh happens:

- Reload at the peak. A new ceiling takes effect at once on the rising slope, so the falling slope keeps the old length and that period is lopsided.
- Reload at the valley. Every period stays mirror-symmetric.

Top module: `pwm_dual_slope`

## Requirements
- R1: The count runs 0,1,…,TOP,TOP-1,…,1,0,1,… Each extreme value is held for exactly one tick. `top_o` is high for the one cycle in which a tick finds the count at TOP while rising. `bottom_o` is high for the one cycle in which a tick finds the count at 0. The two strobes are never high together.
- R2: `clk_sel` picks the tick rate: 0 = stopped (count frozen, no strobes), 1 = every clock, 2 = every 8, 3 = every 64, 4 = every 256, 5 = every 1024, 6 and 7 = stopped. Successive `top_o` strobes are 2·N·TOP clock cycles apart.
- R3: With `out_mode` = 2, the pin goes low when the count arrives at the compare value while rising and goes high when it arrives there while falling. For 0 < CMP < TOP, the pin is high for 2·CMP of every 2·TOP ticks.
- R4: With `out_mode` = 3, every pin level is the complement of mode 2.
- R5: In mode 2, CMP = 0 keeps the pin low and CMP ≥ TOP keeps it high. Mode 3 gives the opposite constant levels.
- R6: With `top_src` = 0, TOP comes from the ceiling register. With `top_src` = 1, TOP comes from the live compare value. Any TOP below 3 is treated as 3.
- R7: With `top_src` = 1 and `out_mode` = 1, the pin inverts each time the count arrives at the compare value. This gives a 50 % duty square wave whose period is two counter periods.
- R8: With `reload_at_bottom` = 0, the buffers are copied to the live registers on the `top_o` tick. After a ceiling change, the falling slope has the old TOP length and the next rising slope has the new TOP length.
- R9: With `reload_at_bottom` = 1, the buffers are copied on the `bottom_o` tick, so both slopes of every period have equal length.
- R10: Writes to the ceiling or the compare value change only the buffers. The live values, and therefore the pin, change only at the reload tick.
- R11: With `out_mode` = 0, or with `out_mode` = 1 while `top_src` = 0, the pin holds its last level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 3 | Tick-rate select |
| reload_at_bottom | input | 1 | 0: reload live values at TOP; 1: reload at BOTTOM |
| top_src | input | 1 | 0: TOP from ceiling register; 1: TOP from compare value |
| out_mode | input | 2 | 0 hold, 1 toggle, 2 non-inverting, 3 inverting |
| top_wr | input | 1 | Write strobe for the ceiling buffer |
| top_wdata | input | 16 | Ceiling write data |
| cmp_wr | input | 1 | Write strobe for the compare buffer |
| cmp_wdata | input | 16 | Compare write data |
| pwm_o | output | 1 | Waveform pin value |
| count_o | output | 16 | Current count |
| top_o | output | 1 | TOP turning-point strobe |
| bottom_o | output | 1 | BOTTOM turning-point strobe |

## Verification
The hardest situation to reach is a buffer write that lands mid-period, followed by the reload tick that separates the two modes. Only from there can the lopsided period in one mode be told apart from the symmetric period in the other.

The stimulus synchronises to a `bottom_o` or `top_o` strobe and writes in the cycle just before that turning point. It then times the next three strobe-to-strobe intervals. It also samples the pin at a chosen falling count, before and after the reload, to show that an early write leaves the pin unchanged.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

  localparam int PRESC_W = 10;

  typedef enum logic [1:0] {
    OUT_OFF    = 2'd0,
    OUT_TOGGLE = 2'd1,
    OUT_NONINV = 2'd2,
    OUT_INV    = 2'd3
  } out_mode_e;

  // Divider runs for selects 1..5 only
  function automatic logic presc_running(input logic [2:0] sel);
    return (sel >= 3'd1) && (sel <= 3'd5);
  endfunction

  // Low-bit mask that must be all ones for a tick
  function automatic logic [PRESC_W-1:0] presc_mask(input logic [2:0] sel);
    case (sel)
      3'd2:    return PRESC_W'(7);
      3'd3:    return PRESC_W'(63);
      3'd4:    return PRESC_W'(255);
      3'd5:    return PRESC_W'(1023);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/pwm_tmr_prescaler.sv
module pwm_tmr_prescaler
  import pwm_tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] clk_sel,
  output logic       tick
);

  logic [PRESC_W-1:0] pre_q;
  logic [PRESC_W-1:0] mask;
  logic               run;

  always_comb begin
    run  = presc_running(clk_sel);
    mask = presc_mask(clk_sel);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   pre_q <= '0;
    else if (!run) pre_q <= '0;
    else          pre_q <= pre_q + 1'b1;
  end

  assign tick = run && ((pre_q & mask) == mask);

  AST_DIV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && clk_sel >= 3'd2 && clk_sel <= 3'd5) |=> (!tick || clk_sel != $past(clk_sel))); // R2

endmodule

// File: rtl/pwm_tmr_updown.sv
module pwm_tmr_updown #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] top_eff,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             dir_nxt,
  output logic             top_evt,
  output logic             bot_evt
);

  logic dir_up_q;

  always_comb begin
    top_evt = tick && dir_up_q && (cnt_q >= top_eff);
    bot_evt = tick && (cnt_q == '0) && !top_evt;
    if (top_evt)             dir_nxt = 1'b0;
    else if (cnt_q == '0)    dir_nxt = 1'b1;
    else                     dir_nxt = dir_up_q;
    cnt_nxt = dir_nxt ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      dir_up_q <= 1'b1;
    end else if (tick) begin
      cnt_q    <= cnt_nxt;
      dir_up_q <= dir_nxt;
    end
  end

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((cnt_q == $past(cnt_q) + CNT_W'(1)) || (cnt_q == $past(cnt_q) - CNT_W'(1)))); // R1
  AST_TURN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    top_evt |=> !dir_up_q); // R1
  AST_TURN_UP: assert property (@(posedge clk) disable iff (!rst_n)
    bot_evt |=> dir_up_q); // R1
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(top_evt && bot_evt)); // R1

endmodule

// File: rtl/pwm_tmr_bufregs.sv
module pwm_tmr_bufregs #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             top_wr,
  input  logic [CNT_W-1:0] top_wdata,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             load,
  output logic [CNT_W-1:0] top_act,
  output logic [CNT_W-1:0] cmp_act
);

  logic [CNT_W-1:0] top_buf, cmp_buf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_buf <= '1;
      cmp_buf <= '0;
    end else begin
      if (top_wr) top_buf <= top_wdata;
      if (cmp_wr) cmp_buf <= cmp_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_act <= '1;
      cmp_act <= '0;
    end else if (load) begin
      top_act <= top_buf;
      cmp_act <= cmp_buf;
    end
  end

  AST_LIVE_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(top_act) && $stable(cmp_act))); // R10

endmodule

// File: rtl/pwm_tmr_wave.sv
module pwm_tmr_wave
  import pwm_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             dir_nxt,
  input  logic [CNT_W-1:0] cmp_act,
  input  logic [CNT_W-1:0] top_eff,
  input  logic [1:0]       out_mode,
  input  logic             top_src,
  output logic             pin_q
);

  logic hit;
  logic lvl_cur, lvl_nxt;
  logic pin_d;

  always_comb begin
    hit     = tick && (cnt_nxt == cmp_act);
    lvl_cur = (out_mode == OUT_INV) ? ~pin_q : pin_q;
    if (cmp_act == '0)          lvl_nxt = 1'b0;
    else if (cmp_act >= top_eff) lvl_nxt = 1'b1;
    else if (hit)               lvl_nxt = ~dir_nxt;
    else                        lvl_nxt = lvl_cur;
    pin_d = pin_q;
    case (out_mode)
      OUT_TOGGLE: if (top_src && hit) pin_d = ~pin_q;
      OUT_NONINV: if (tick)           pin_d = lvl_nxt;
      OUT_INV:    if (tick)           pin_d = ~lvl_nxt;
      default:    pin_d = pin_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == OUT_OFF) |=> $stable(pin_q)); // R11
  AST_ZERO_CMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && out_mode == OUT_NONINV && cmp_act == '0) |=> !pin_q); // R5

endmodule

// File: rtl/pwm_dual_slope.sv
module pwm_dual_slope #(
  parameter int CNT_W   = 16,
  parameter int TOP_MIN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       clk_sel,
  input  logic             reload_at_bottom,
  input  logic             top_src,
  input  logic [1:0]       out_mode,
  input  logic             top_wr,
  input  logic [CNT_W-1:0] top_wdata,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic             pwm_o,
  output logic [CNT_W-1:0] count_o,
  output logic             top_o,
  output logic             bottom_o
);

  localparam logic [CNT_W-1:0] TOP_FLOOR = CNT_W'(TOP_MIN);

  function automatic logic [CNT_W-1:0] clamp_top(input logic [CNT_W-1:0] v);
    return (v < TOP_FLOOR) ? TOP_FLOOR : v;
  endfunction

  logic             tick;
  logic [CNT_W-1:0] top_act, cmp_act, top_eff;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             dir_nxt, top_evt, bot_evt, load;

  assign top_eff = clamp_top(top_src ? cmp_act : top_act);
  assign load    = reload_at_bottom ? bot_evt : top_evt;

  pwm_tmr_prescaler u_presc (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .tick(tick)
  );

  pwm_tmr_updown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .top_eff(top_eff),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .dir_nxt(dir_nxt),
    .top_evt(top_evt), .bot_evt(bot_evt)
  );

  pwm_tmr_bufregs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .top_wr(top_wr), .top_wdata(top_wdata),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .load(load), .top_act(top_act), .cmp_act(cmp_act)
  );

  pwm_tmr_wave #(.CNT_W(CNT_W)) u_wave (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_nxt(cnt_nxt),
    .dir_nxt(dir_nxt), .cmp_act(cmp_act), .top_eff(top_eff),
    .out_mode(out_mode), .top_src(top_src), .pin_q(pwm_o)
  );

  assign count_o  = cnt_q;
  assign top_o    = top_evt;
  assign bottom_o = bot_evt;

  AST_TOP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    top_o |-> (count_o >= TOP_FLOOR)); // R6
  AST_PFC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_at_bottom && top_o) |=> $stable(top_act)); // R9

endmodule

// File: tb/pwm_dual_slope_tb.sv
module pwm_dual_slope_tb;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        mode;
    logic        src;
    logic [1:0]  com;
    logic [15:0] top;
    logic [15:0] cmp;
    int          win;
    int          hi;
    int          per;
    int          req;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 2'd2, 16'd20, 16'd15, 40, 30, 40, 3},  // R3 reload at bottom
    '{1'b0, 1'b0, 2'd2, 16'd20, 16'd5,  40, 10, 40, 3},  // R3
    '{1'b0, 1'b0, 2'd3, 16'd20, 16'd5,  40, 30, 40, 4},  // R4
    '{1'b0, 1'b0, 2'd2, 16'd20, 16'd0,  40, 0,  40, 5},  // R5 low
    '{1'b0, 1'b0, 2'd2, 16'd20, 16'd20, 40, 40, 40, 5},  // R5 high
    '{1'b1, 1'b0, 2'd3, 16'd20, 16'd0,  40, 40, 40, 5},  // R5 inverted
    '{1'b1, 1'b0, 2'd3, 16'd12, 16'd12, 24, 0,  24, 5},  // R5 inverted
    '{1'b0, 1'b1, 2'd1, 16'd40, 16'd9,  36, 18, 18, 7},  // R7, R6 ceiling reg ignored
    '{1'b1, 1'b0, 2'd2, 16'd3,  16'd1,  6,  2,  6,  6},  // R6 minimum
    '{1'b0, 1'b0, 2'd2, 16'd1,  16'd1,  6,  2,  6,  6}   // R6 clamp
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  clk_sel = 3'd0;
  logic        reload_at_bottom = 1'b0;
  logic        top_src = 1'b0;
  logic [1:0]  out_mode = 2'd0;
  logic        top_wr = 1'b0;
  logic [15:0] top_wdata = '0;
  logic        cmp_wr = 1'b0;
  logic [15:0] cmp_wdata = '0;
  logic        pwm_o, top_o, bottom_o;
  logic [15:0] count_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_dual_slope u_dut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel),
    .reload_at_bottom(reload_at_bottom), .top_src(top_src),
    .out_mode(out_mode), .top_wr(top_wr), .top_wdata(top_wdata),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .pwm_o(pwm_o),
    .count_o(count_o), .top_o(top_o), .bottom_o(bottom_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wait_top();
    step();
    while (!top_o) step();
  endtask

  task automatic wait_bottom();
    step();
    while (!bottom_o) step();
  endtask

  task automatic count_to_top(output int n);
    n = 0;
    do begin step(); n++; end while (!top_o);
  endtask

  task automatic count_to_bottom(output int n);
    n = 0;
    do begin step(); n++; end while (!bottom_o);
  endtask

  task automatic load_cfg(input logic mode, input logic src, input logic [1:0] com,
                          input logic [15:0] top, input logic [15:0] cmp);
    @(negedge clk);
    reload_at_bottom = mode; top_src = src; out_mode = com;
    top_wr = 1'b1; top_wdata = top; cmp_wr = 1'b1; cmp_wdata = cmp;
    @(negedge clk);
    top_wr = 1'b0; cmp_wr = 1'b0; clk_sel = 3'd1;
    repeat (3) wait_bottom();
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n1, n2, n3, hi, errs, c0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step();
    // R1 reset state, stopped divider (R2)
    check(count_o == 16'd0, "R1 reset count", int'(count_o), 0);
    check(pwm_o == 1'b0, "R1 reset pin", int'(pwm_o), 0);
    check(top_o == 1'b0, "R1 reset top strobe", int'(top_o), 0);
    check(bottom_o == 1'b0, "R2 stopped bottom strobe", int'(bottom_o), 0);

    // Table walk: duty and period per vector
    for (int k = 0; k < NVEC; k++) begin
      vec_t v;
      v = VECS[k];
      load_cfg(v.mode, v.src, v.com, v.top, v.cmp);
      wait_bottom();
      hi = 0;
      for (int i = 0; i < v.win; i++) begin step(); hi += int'(pwm_o); end
      check(hi == v.hi, $sformatf("R%0d duty vec%0d", v.req, k), hi, v.hi);
      wait_top();
      count_to_top(n1);
      check(n1 == v.per, $sformatf("R2 period vec%0d", k), n1, v.per);
    end

    // R1 triangle sequence with one-tick extremes and strobes
    load_cfg(1'b0, 1'b0, 2'd2, 16'd5, 16'd2);
    wait_bottom();
    errs = 0;
    for (int i = 1; i <= 10; i++) begin
      int e;
      e = (i <= 5) ? i : 10 - i;
      step();
      if (count_o != 16'(e)) errs++;
      if (top_o != (i == 5)) errs++;
      if (bottom_o != (i == 10)) errs++;
    end
    check(errs == 0, "R1 count sequence", errs, 0);

    // R8 ceiling change with reload at TOP: lopsided period
    load_cfg(1'b0, 1'b0, 2'd2, 16'd20, 16'd5);
    wait_bottom();
    @(negedge clk); top_wr = 1'b1; top_wdata = 16'd30;
    @(negedge clk); top_wr = 1'b0;
    wait_top();
    count_to_bottom(n1);
    count_to_top(n2);
    check(n1 == 20, "R8 falling slope old TOP", n1, 20);
    check(n2 == 30, "R8 rising slope new TOP", n2, 30);

    // R9 ceiling change with reload at BOTTOM: symmetric period
    load_cfg(1'b1, 1'b0, 2'd2, 16'd20, 16'd5);
    wait_bottom();
    @(negedge clk); top_wr = 1'b1; top_wdata = 16'd30;
    @(negedge clk); top_wr = 1'b0;
    wait_top();
    count_to_bottom(n1);
    count_to_top(n2);
    count_to_bottom(n3);
    check(n1 == 20, "R9 old period falling", n1, 20);
    check(n2 == 30 && n3 == 30, "R9 symmetric slopes", n2 * 100 + n3, 3030);

    // R10 compare write stays in buffer until the TOP reload
    load_cfg(1'b0, 1'b0, 2'd2, 16'd20, 16'd5);
    wait_top();
    @(negedge clk); cmp_wr = 1'b1; cmp_wdata = 16'd15;
    @(negedge clk); cmp_wr = 1'b0;
    step();
    while (count_o != 16'd14) step();
    check(pwm_o == 1'b0, "R10 buffered compare not live", int'(pwm_o), 0);
    wait_top();
    step();
    while (count_o != 16'd14) step();
    check(pwm_o == 1'b1, "R8 compare live after TOP reload", int'(pwm_o), 1);

    // R11 hold: mode 0, then toggle without compare-sourced TOP
    load_cfg(1'b0, 1'b0, 2'd2, 16'd20, 16'd5);
    step();
    while (count_o != 16'd2) step();
    check(pwm_o == 1'b1, "R3 level near bottom", int'(pwm_o), 1);
    @(negedge clk); out_mode = 2'd0;
    errs = 0;
    for (int i = 0; i < 60; i++) begin step(); if (pwm_o != 1'b1) errs++; end
    check(errs == 0, "R11 mode 0 holds", errs, 0);
    @(negedge clk); out_mode = 2'd1;
    errs = 0;
    for (int i = 0; i < 60; i++) begin step(); if (pwm_o != 1'b1) errs++; end
    check(errs == 0, "R11 toggle with ceiling reg holds", errs, 0);

    // R2 divided tick rates
    load_cfg(1'b0, 1'b0, 2'd2, 16'd4, 16'd2);
    @(negedge clk); clk_sel = 3'd2;
    wait_top();
    count_to_top(n1);
    check(n1 == 64, "R2 divide by 8", n1, 64);
    load_cfg(1'b0, 1'b0, 2'd2, 16'd3, 16'd1);
    @(negedge clk); clk_sel = 3'd3;
    wait_top();
    count_to_top(n1);
    check(n1 == 384, "R2 divide by 64", n1, 384);

    // R2 stopped divider freezes the count
    @(negedge clk); clk_sel = 3'd0;
    step();
    c0 = int'(count_o);
    errs = 0;
    for (int i = 0; i < 50; i++) begin
      step();
      if (int'(count_o) != c0 || top_o || bottom_o) errs++;
    end
    check(errs == 0, "R2 stopped count frozen", errs, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule